// File: doc/BRIEF.md
# Lockable Watchdog Timer with Keepalive

The block is a watchdog timer that sits behind a small 16-bit register port with three word offsets: a control word, the low half of the live count and the high half of the live count. A 32-bit counter advances by one on every clock while the timer is enabled. The period is picked by a one-hot exponent field that names one binary stage of that counter. When the chosen stage rises from 0 to 1, the block sets a sticky interrupt flag. If reset-on-timeout is enabled, it also raises a reset request for one cycle.

Software has two ways to affect the timer, and both are two-word sequences written to the control offset. The first way unlocks the next control write: write 0x3333, then 0xCCCC, and the next control write takes effect. The second way restarts the count from zero: write 0xAAAA, then 0x5555. A single tracker state machine follows these sequences. It has four states:

- SEQ_IDLE, the start state.
- SEQ_UNL_A, entered after 0x3333 arrives in SEQ_IDLE.
- SEQ_UNLOCKED, entered after 0xCCCC arrives in SEQ_UNL_A.
- SEQ_KICK_A, entered after 0xAAAA arrives in SEQ_IDLE.

The tracker takes these transitions:

- SEQ_UNLOCKED to SEQ_IDLE on the next control write. That write is committed.
- SEQ_KICK_A to SEQ_IDLE on the next control write. If that word is 0x5555, the count restarts.
- Any other control write returns the tracker to SEQ_IDLE with no other effect.

Writes to the other offsets do not move the tracker.

Top module: `wdog_lockable`

## Requirements
- R1: After reset the control word reads 0x0001 (timer off, reset-on-timeout off, flag clear, stage 14), the count reads zero, and irq and rst_req are low.
- R2: A write to offset 0 updates the control word only when the two control writes just before it were 0x3333 and then 0xCCCC. Any other control write leaves the control word unchanged.
- R3: A control write of 0xAAAA directly followed by a control write of 0x5555 sets the count to zero on the clock edge of the second write.
- R4: A control write that does not continue a sequence returns the tracker to idle with no effect. Writes to offsets 1 to 3 are ignored and do not break a sequence in progress.
- R5: Bits 7:0 of the control word are a one-hot stage select: bit 0 picks stage 14, and bit k (k = 1..7) picks stage 23+k. A committed write whose bits 7:0 are not one-hot keeps the previous selection.
- R6: While enabled (bit 15), the count increases by one per clock. The clock edge on which the selected count bit goes from 0 to 1 sets the flag (bit 12), which drives irq.
- R7: If bit 14 was 1 at that timeout edge, rst_req is high for exactly one cycle after it. Otherwise rst_req stays low.
- R8: A committed control write with bit 12 set clears the flag. With bit 12 clear, the flag is kept. A timeout in the same cycle wins over the clear.
- R9: While bit 15 is 0, the count is held at zero and no flag or reset request is produced.
- R10: Reads are combinational. Offset 0 returns the control word, with bits 13 and 11:8 read as zero. Offset 1 returns count bits 15:0, offset 2 returns count bits 31:16, and offset 3 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one word per cycle |
| addr | input | 2 | Word offset for read and write |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for addr |
| irq | output | 1 | Sticky timeout flag |
| rst_req | output | 1 | One-cycle reset request on timeout |

## Verification
The assertions assume several properties of the inputs. A write lasts one cycle with a stable address and data. The reset is held for several clocks. The exponent register only ever holds a one-hot value, which must hold from reset onward.

The stimulus changes the inputs just after a rising edge and samples in the middle of the cycle. It issues writes one at a time through a task, and it only ever commits control words whose effect the reference model predicts. That includes deliberately non-one-hot exponents, so the keep-previous rule is exercised without ever breaking the one-hot assumption.

// File: rtl/wdog_lockable_pkg.sv
package wdog_lockable_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_UNL_A,
        SEQ_UNLOCKED,
        SEQ_KICK_A
    } seq_state_t;

    localparam int          WORD_W     = 16;
    localparam logic [15:0] KEY_UNL_A  = 16'h3333;
    localparam logic [15:0] KEY_UNL_B  = 16'hCCCC;
    localparam logic [15:0] KEY_KICK_A = 16'hAAAA;
    localparam logic [15:0] KEY_KICK_B = 16'h5555;

    // control word bit positions (software-visible layout)
    localparam int BIT_RUN   = 15;
    localparam int BIT_RSTEN = 14;
    localparam int BIT_FLAG  = 12;

    localparam logic [1:0] OFS_CTL = 2'd0;
    localparam logic [1:0] OFS_LO  = 2'd1;
    localparam logic [1:0] OFS_HI  = 2'd2;

endpackage

// File: rtl/wdog_lockable_seq.sv
module wdog_lockable_seq
    import wdog_lockable_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ctl_wr,
    input  logic [WORD_W-1:0]   wdata,
    output logic                commit,
    output logic                kick
);

    seq_state_t state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEQ_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (ctl_wr) begin
            unique case (state_q)
                SEQ_IDLE: begin
                    if (wdata == KEY_UNL_A)       state_d = SEQ_UNL_A;
                    else if (wdata == KEY_KICK_A) state_d = SEQ_KICK_A;
                    else                          state_d = SEQ_IDLE;
                end
                SEQ_UNL_A: begin
                    if (wdata == KEY_UNL_B) state_d = SEQ_UNLOCKED;
                    else                    state_d = SEQ_IDLE;
                end
                SEQ_UNLOCKED: state_d = SEQ_IDLE;
                SEQ_KICK_A:   state_d = SEQ_IDLE;
                default:      state_d = SEQ_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        commit = 1'b0;
        kick   = 1'b0;
        unique case (state_q)
            SEQ_UNLOCKED: commit = ctl_wr;
            SEQ_KICK_A:   kick   = ctl_wr && (wdata == KEY_KICK_B);
            default: ;
        endcase
    end

endmodule

// File: rtl/wdog_lockable_count.sv
module wdog_lockable_count #(
    parameter int CNT_W       = 32,
    parameter int EXP_W       = 8,
    parameter int FIRST_STAGE = 14,
    parameter int BASE_STAGE  = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             kick,
    input  logic [EXP_W-1:0] exp_sel,
    output logic [CNT_W-1:0] cnt,
    output logic             expire
);

    logic [EXP_W-1:0] hit;

    // one carry detector per selectable stage
    for (genvar k = 0; k < EXP_W; k++) begin : g_stage
        localparam int STG = (k == 0) ? FIRST_STAGE : BASE_STAGE + k - 1;
        assign hit[k] = exp_sel[k] && !cnt[STG] && (&cnt[STG-1:0]);
    end

    assign expire = run && !kick && (|hit);

    always_ff @(posedge clk) begin
        if (!rst_n)            cnt <= '0;
        else if (kick || !run) cnt <= '0;
        else                   cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/wdog_lockable.sv
module wdog_lockable
    import wdog_lockable_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int EXP_W       = 8,
    parameter int FIRST_STAGE = 14,
    parameter int BASE_STAGE  = 24
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [1:0]  addr,
    input  logic [15:0] wdata,
    output logic [15:0] rdata,
    output logic        irq,
    output logic        rst_req
);

    localparam logic [EXP_W-1:0] EXP_RST = EXP_W'(1);

    logic             ctl_wr, commit, kick, expire;
    logic             run_q, rsten_q, flag_q, rreq_q;
    logic [EXP_W-1:0] exp_q;
    logic [CNT_W-1:0] cnt;
    logic [WORD_W-1:0] ctl_word;

    assign ctl_wr = wr_en && (addr == OFS_CTL);

    wdog_lockable_seq u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .ctl_wr (ctl_wr),
        .wdata  (wdata),
        .commit (commit),
        .kick   (kick)
    );

    wdog_lockable_count #(
        .CNT_W       (CNT_W),
        .EXP_W       (EXP_W),
        .FIRST_STAGE (FIRST_STAGE),
        .BASE_STAGE  (BASE_STAGE)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run_q),
        .kick    (kick),
        .exp_sel (exp_q),
        .cnt     (cnt),
        .expire  (expire)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q   <= 1'b0;
            rsten_q <= 1'b0;
            exp_q   <= EXP_RST;
        end else if (commit) begin
            run_q   <= wdata[BIT_RUN];
            rsten_q <= wdata[BIT_RSTEN];
            if ($countones(wdata[EXP_W-1:0]) == 1) exp_q <= wdata[EXP_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
            rreq_q <= 1'b0;
        end else begin
            rreq_q <= expire && rsten_q;
            if (expire)                          flag_q <= 1'b1;
            else if (commit && wdata[BIT_FLAG])  flag_q <= 1'b0;
        end
    end

    always_comb begin
        ctl_word                = '0;
        ctl_word[BIT_RUN]       = run_q;
        ctl_word[BIT_RSTEN]     = rsten_q;
        ctl_word[BIT_FLAG]      = flag_q;
        ctl_word[EXP_W-1:0]     = exp_q;
    end

    always_comb begin
        case (addr)
            OFS_CTL: rdata = ctl_word;
            OFS_LO:  rdata = cnt[15:0];
            OFS_HI:  rdata = cnt[31:16];
            default: rdata = '0;
        endcase
    end

    assign irq     = flag_q;
    assign rst_req = rreq_q;

endmodule

// File: rtl/wdog_lockable_chk.sv
module wdog_lockable_chk #(
    parameter int CNT_W = 32,
    parameter int EXP_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             commit,
    input logic             kick,
    input logic             expire,
    input logic             run_q,
    input logic             rsten_q,
    input logic [EXP_W-1:0] exp_q,
    input logic [CNT_W-1:0] cnt,
    input logic             irq,
    input logic             rst_req
);

    a_r2_ctl_locked: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable({run_q, rsten_q, exp_q}));

    a_r3_kick_zero: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> (cnt == '0));

    a_r5_exp_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(exp_q) == 1);

    a_r6_expire_flags: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> irq);

    a_r7_req_single: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    a_r7_req_with_irq: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> irq);

    a_r9_idle_no_event: assert property (@(posedge clk) disable iff (!rst_n)
        !run_q |-> !expire);

    a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !commit) |=> (cnt == '0));

endmodule

bind wdog_lockable wdog_lockable_chk #(.CNT_W(CNT_W), .EXP_W(EXP_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .commit  (commit),
    .kick    (kick),
    .expire  (expire),
    .run_q   (run_q),
    .rsten_q (rsten_q),
    .exp_q   (exp_q),
    .cnt     (cnt),
    .irq     (irq),
    .rst_req (rst_req)
);

// File: tb/wdog_lockable_tb.sv
module wdog_lockable_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = 2'd1;
    logic [15:0] wdata = 16'h0;
    logic [15:0] rdata;
    logic        irq, rst_req;

    int total = 0;
    int bad = 0;
    int pulses = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    wdog_lockable dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq(irq), .rst_req(rst_req)
    );

    // ---------------- behavioural reference model ----------------
    logic [31:0] m_cnt;
    bit          m_run, m_rse, m_flag, m_rreq;
    logic [7:0]  m_exp;
    int          m_phase;   // 0 idle, 1 got first unlock word, 2 unlocked, 3 got first kick word

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_run = 0; m_rse = 0; m_flag = 0; m_rreq = 0;
            m_exp = 8'h01; m_phase = 0;
        end else begin
            bit commit_m, kick_m, ev;
            int stg;
            logic [31:0] nxt;
            commit_m = 0; kick_m = 0; stg = 14;
            if (wr_en && addr == 2'd0) begin
                case (m_phase)
                    0: m_phase = (wdata == 16'h3333) ? 1 : (wdata == 16'hAAAA) ? 3 : 0;
                    1: m_phase = (wdata == 16'hCCCC) ? 2 : 0;
                    2: begin commit_m = 1; m_phase = 0; end
                    default: begin kick_m = (wdata == 16'h5555); m_phase = 0; end
                endcase
            end
            for (int k = 0; k < 8; k++) if (m_exp[k]) stg = (k == 0) ? 14 : 23 + k;
            nxt = m_cnt + 1;
            ev = m_run && !kick_m && !m_cnt[stg] && nxt[stg];
            m_rreq = ev && m_rse;
            if (ev) m_flag = 1;
            else if (commit_m && wdata[12]) m_flag = 0;
            m_cnt = (kick_m || !m_run) ? 32'h0 : nxt;
            if (commit_m) begin
                m_run = wdata[15];
                m_rse = wdata[14];
                if ($countones(wdata[7:0]) == 1) m_exp = wdata[7:0];
            end
        end
    end

    function automatic logic [15:0] model_rd(input logic [1:0] a);
        case (a)
            2'd0: return {m_run, m_rse, 1'b0, m_flag, 4'h0, m_exp};
            2'd1: return m_cnt[15:0];
            2'd2: return m_cnt[31:16];
            default: return 16'h0;
        endcase
    endfunction

    // per-cycle comparison, mid-cycle
    always @(negedge clk) begin
        if (rst_n && !done) begin
            total++;
            if (rdata !== model_rd(addr)) begin
                bad++;
                $display("FAIL R10 rdata addr=%0d actual=%h expected=%h", addr, rdata, model_rd(addr));
            end
            total++;
            if (irq !== m_flag) begin
                bad++;
                $display("FAIL R6 irq actual=%b expected=%b", irq, m_flag);
            end
            total++;
            if (rst_req !== m_rreq) begin
                bad++;
                $display("FAIL R7 rst_req actual=%b expected=%b", rst_req, m_rreq);
            end
            if (rst_req) pulses++;
        end
    end

    // ---------------- helpers ----------------
    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp_v);
        total++;
        if (act !== exp_v) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp_v);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        wr_en = 1'b0; addr = 2'd1;
    endtask

    task automatic ctl_commit(input logic [15:0] d);
        wr(2'd0, 16'h3333);
        wr(2'd0, 16'hCCCC);
        wr(2'd0, d);
    endtask

    task automatic keepalive();
        wr(2'd0, 16'hAAAA);
        wr(2'd0, 16'h5555);
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] v);
        @(posedge clk); #1;
        addr = a;
        @(negedge clk);
        v = rdata;
    endtask

    task automatic wait_irq(input int limit);
        for (int i = 0; i < limit && !irq; i++) @(negedge clk);
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            summary();
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        logic [15:0] v;
        int p0;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd(2'd0, v); check("R1 ctl after reset", v, 16'h0001);
        rd(2'd1, v); check("R1 count low after reset", v, 16'h0000);
        @(negedge clk); check("R1 irq/rst_req after reset", {irq, rst_req}, 2'b00);

        // R2 control write without unlock is ignored
        wr(2'd0, 16'h8001);
        rd(2'd0, v); check("R2 plain write ignored", v, 16'h0001);

        // R2 unlocked write takes effect
        ctl_commit(16'h8001);
        rd(2'd0, v); check("R2 unlocked write", v, 16'h8001);

        repeat (5000) @(posedge clk);
        rd(2'd1, v); check("R6 count advancing", {31'h0, v > 16'd4000}, 32'h1);

        // R3 keepalive zeroes the count
        keepalive();
        @(negedge clk); check("R3 count zero after keepalive", rdata, 16'h0000);

        // R4 broken unlock sequence, then stray offsets do not break it
        wr(2'd0, 16'h3333);
        wr(2'd0, 16'hAAAA);
        wr(2'd0, 16'hCCCC);
        wr(2'd0, 16'h0000);
        rd(2'd0, v); check("R4 broken sequence ignored", v, 16'h8001);
        wr(2'd0, 16'h3333);
        wr(2'd2, 16'h1234);
        wr(2'd0, 16'hCCCC);
        wr(2'd0, 16'h8001);
        rd(2'd0, v); check("R4 other offset keeps sequence", v, 16'h8001);
        wr(2'd0, 16'hAAAA);
        wr(2'd0, 16'h1111);
        rd(2'd1, v); check("R4 bad kick word ignored", {31'h0, v > 16'd2}, 32'h1);

        // R6/R7 timeout without reset enable
        keepalive();
        p0 = pulses;
        wait_irq(20000);
        check("R6 irq on timeout", {31'h0, irq}, 32'h1);
        rd(2'd0, v); check("R6 flag bit12 set", {31'h0, v[12]}, 32'h1);
        repeat (4) @(posedge clk);
        check("R7 no reset request when disabled", pulses - p0, 0);

        // R8 clear flag, enable reset, time out again
        ctl_commit(16'hD001);
        rd(2'd0, v); check("R8 flag cleared", v, 16'hC001);
        keepalive();
        p0 = pulses;
        wait_irq(20000);
        repeat (4) @(posedge clk);
        check("R7 exactly one reset request", pulses - p0, 1);

        // R5 non-one-hot keeps selection, R8 bit12 clear keeps flag
        ctl_commit(16'h4003);
        rd(2'd0, v); check("R5 R8 non-onehot kept, flag kept", v, 16'h5001);
        ctl_commit(16'h1002);
        rd(2'd0, v); check("R5 stage 24 selected", v, 16'h0002);

        // R9 disabled: count zero, no event
        repeat (20000) @(posedge clk);
        rd(2'd1, v); check("R9 count held at zero", v, 16'h0000);
        check("R9 no irq when disabled", {31'h0, irq}, 32'h0);

        // R5 stage 24 does not expire at the stage-14 point
        ctl_commit(16'h8002);
        repeat (20000) @(posedge clk);
        @(negedge clk); check("R5 no early timeout at stage 24", {31'h0, irq}, 32'h0);
        rd(2'd2, v); check("R10 high half", v, 16'h0000);
        rd(2'd3, v); check("R10 offset 3 zero", v, 16'h0000);

        done = 1'b1;
        summary();
    end

endmodule